// File: doc/BRIEF.md
# Digital Video Line Timing Generator

This block sits on an 8-bit 4:2:2 digital video byte stream that arrives one byte per pixel clock. It finds the start of each line, either from the rising edge of an external horizontal sync input or from an embedded start-of-active-video code carried in the stream itself. A control bit picks which of the two is used. From that reference it runs a horizontal sample counter, which wraps at a programmable line length.

The counter drives several outputs. A programmable active-window flag has independent start and end positions, and a component tag tells which output bytes carry Cb, Y and Cr. A sync pulse is generated when the line reference is taken from the embedded code. A half-rate clock is re-phased so that it rises with the window's leading edge. Line-valid and field flags are captured at every line reference, and each has its own output polarity.

The bytes pass through a fixed pipeline. The window flag, the tag and the generated sync are produced in the same stages as the bytes, so they stay aligned with the data they describe. Configuration is by single-cycle parallel register writes.

Top module: `vid_line_timer`

## Requirements
- R1: While rst_n is low, every output is 0 and the sample counter is 0. The first byte presented after reset release is at count 0. The register reset values are: window start 8, window end 39, line total 64, sync start 0, sync end 4, control 0.
- R2: dout equals din delayed by exactly PIPE_DEPTH clock cycles (3 by default).
- R3: In external mode (control bit 0 = 0), a rising edge of hsync_in (high in this cycle, low in the previous one) makes the next byte count 0. Between such edges the count rises by one per byte and returns to 0 after the value line_total-1. An edge may arrive at any count.
- R4: In embedded mode (control bit 0 = 1), the sequence 0xFF, 0x00, 0x00, XY with XY bit 4 = 0 makes the byte after XY count 0. Codes with XY bit 4 = 1 do not restart the counter, and hsync_in is ignored.
- R5: window_o is high, in the same cycle as dout, for exactly those bytes whose count c satisfies start <= c <= end. Register addresses are 0 = window start and 1 = window end.
- R6: When window end <= window start, window_o stays low for the whole line.
- R7: Inside the window, comp_o equals (c - start) mod 4, with the encoding 0 = Cb, 1 = Y, 2 = Cr, 3 = Y. Outside the window comp_o is 0.
- R8: half_clk_o is 1 in the first output cycle of each window and inverts on every other cycle.
- R9: The flags are captured at each line reference. In embedded mode, line valid = (XY bit 5 == 0) and field active = (XY bit 6 == 0). In external mode, line valid = !vblank_in and field active = field_in. Control bit 1 inverts valid_line_o and control bit 2 inverts field_o. Both take effect on the cycle after the write.
- R10: In embedded mode, sync_o is high, aligned with dout, for counts sync_start <= c < sync_end (addresses 3 and 4). In external mode sync_o stays 0 whatever those registers hold.
- R11: A write with wr_en high takes effect from the byte presented in the following cycle. Address 2 is line_total and address 5 is control. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 8 | Incoming video byte |
| hsync_in | input | 1 | External horizontal sync (external mode) |
| vblank_in | input | 1 | External vertical blanking level, sampled at reference |
| field_in | input | 1 | External field level, sampled at reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Register write data |
| dout | output | 8 | Delayed video byte |
| window_o | output | 1 | Active-window flag aligned to dout |
| comp_o | output | 2 | Component tag aligned to dout |
| sync_o | output | 1 | Generated sync aligned to dout |
| half_clk_o | output | 1 | Half-rate clock phased to window start |
| valid_line_o | output | 1 | Line-valid flag, programmable polarity |
| field_o | output | 1 | Field flag, programmable polarity |

## Verification
A line reference can land in the same cycle as the counter's natural wrap. It can also land inside the active window, forcing a restart while the window is open. The bench provokes both by sending lines both shorter and longer than line_total in external mode, and by sweeping window start and end around those points. The second overlap is between the half-rate clock's free toggle and its forced re-phase at a window leading edge. Both overlaps are judged against a count and phase model kept in the bench: every output byte's window flag, tag and half-clock level is compared with values computed from the requirements.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

    typedef enum logic [1:0] {
        COMP_CB = 2'd0,
        COMP_YA = 2'd1,
        COMP_CR = 2'd2,
        COMP_YB = 2'd3
    } comp_e;

    localparam logic [2:0] REG_WIN_START  = 3'd0;
    localparam logic [2:0] REG_WIN_END    = 3'd1;
    localparam logic [2:0] REG_LINE_TOTAL = 3'd2;
    localparam logic [2:0] REG_SYNC_START = 3'd3;
    localparam logic [2:0] REG_SYNC_END   = 3'd4;
    localparam logic [2:0] REG_CTRL       = 3'd5;

    localparam int CTRL_REF_EMB = 0;
    localparam int CTRL_VLD_POL = 1;
    localparam int CTRL_FLD_POL = 2;

    localparam int XY_H = 4;
    localparam int XY_V = 5;
    localparam int XY_F = 6;

endpackage

// File: rtl/vlt_code_detect.sv
module vlt_code_detect #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic              hit,
    output logic              h_bit,
    output logic              v_bit,
    output logic              f_bit
);
    import vlt_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] h1;
        logic [DATA_W-1:0] h2;
        logic [DATA_W-1:0] h3;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.h1 = din;
        st_d.h2 = st_q.h1;
        st_d.h3 = st_q.h2;
        hit     = (st_q.h3 == '1) && (st_q.h2 == '0) && (st_q.h1 == '0);
        h_bit   = din[XY_H];
        v_bit   = din[XY_V];
        f_bit   = din[XY_F];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/vlt_hcounter.sv
module vlt_hcounter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart)                   cnt_d = '0;
        else if (cnt_q >= total - ONE) cnt_d = '0;
        else                           cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/vlt_out_pipe.sv
module vlt_out_pipe #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 12,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  win_start,
    input  logic [CNT_W-1:0]  win_end,
    input  logic [CNT_W-1:0]  sync_start,
    input  logic [CNT_W-1:0]  sync_end,
    input  logic              sync_en,
    output logic [DATA_W-1:0] dout,
    output logic              win,
    output vlt_pkg::comp_e    comp,
    output logic              sync,
    output logic              half_clk
);
    import vlt_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              win;
        comp_e             comp;
        logic              sync;
    } stage_t;

    typedef struct packed {
        stage_t [DEPTH-1:0] stg;
        logic               half;
    } pipe_t;

    pipe_t  st_d, st_q;
    stage_t entry;
    logic   feed_win;

    // Window, tag and sync decided at pipeline entry, then carried with the byte
    always_comb begin
        entry.data = din;
        entry.win  = (win_end > win_start) && (cnt >= win_start) && (cnt <= win_end);
        entry.comp = entry.win ? comp_e'(cnt[1:0] - win_start[1:0]) : COMP_CB;
        entry.sync = sync_en && (cnt >= sync_start) && (cnt < sync_end);
    end

    generate
        if (DEPTH == 1) begin : g_single
            assign feed_win = entry.win;
        end else begin : g_chain
            assign feed_win = st_q.stg[DEPTH-2].win;
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = entry;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
        // Re-phase on the window leading edge, free toggle elsewhere
        if (feed_win && !st_q.stg[DEPTH-1].win) st_d.half = 1'b1;
        else                                    st_d.half = ~st_q.half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout     = st_q.stg[DEPTH-1].data;
    assign win      = st_q.stg[DEPTH-1].win;
    assign comp     = st_q.stg[DEPTH-1].comp;
    assign sync     = st_q.stg[DEPTH-1].sync;
    assign half_clk = st_q.half;

endmodule

// File: rtl/vid_line_timer.sv
module vid_line_timer #(
    parameter int DATA_W         = 8,
    parameter int CNT_W          = 12,
    parameter int PIPE_DEPTH     = 3,
    parameter int RST_WIN_START  = 8,
    parameter int RST_WIN_END    = 39,
    parameter int RST_LINE_TOTAL = 64,
    parameter int RST_SYNC_START = 0,
    parameter int RST_SYNC_END   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              hsync_in,
    input  logic              vblank_in,
    input  logic              field_in,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [DATA_W-1:0] dout,
    output logic              window_o,
    output logic [1:0]        comp_o,
    output logic              sync_o,
    output logic              half_clk_o,
    output logic              valid_line_o,
    output logic              field_o
);
    import vlt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] win_start;
        logic [CNT_W-1:0] win_end;
        logic [CNT_W-1:0] line_total;
        logic [CNT_W-1:0] sync_start;
        logic [CNT_W-1:0] sync_end;
        logic             ref_emb;
        logic             vld_pol;
        logic             fld_pol;
        logic             hs_prev;
        logic             line_valid;
        logic             field_odd;
    } top_t;

    top_t st_d, st_q;

    logic             code_hit, code_h, code_v, code_f;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    comp_e            pipe_comp;

    vlt_code_detect #(.DATA_W(DATA_W)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .hit   (code_hit),
        .h_bit (code_h),
        .v_bit (code_v),
        .f_bit (code_f)
    );

    always_comb begin
        if (st_q.ref_emb) restart = code_hit && !code_h;
        else              restart = hsync_in && !st_q.hs_prev;
    end

    vlt_hcounter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .total   (st_q.line_total),
        .cnt     (cnt)
    );

    vlt_out_pipe #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .cnt        (cnt),
        .win_start  (st_q.win_start),
        .win_end    (st_q.win_end),
        .sync_start (st_q.sync_start),
        .sync_end   (st_q.sync_end),
        .sync_en    (st_q.ref_emb),
        .dout       (dout),
        .win        (window_o),
        .comp       (pipe_comp),
        .sync       (sync_o),
        .half_clk   (half_clk_o)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                REG_WIN_START:  st_d.win_start  = wr_data;
                REG_WIN_END:    st_d.win_end    = wr_data;
                REG_LINE_TOTAL: st_d.line_total = wr_data;
                REG_SYNC_START: st_d.sync_start = wr_data;
                REG_SYNC_END:   st_d.sync_end   = wr_data;
                REG_CTRL: begin
                    st_d.ref_emb = wr_data[CTRL_REF_EMB];
                    st_d.vld_pol = wr_data[CTRL_VLD_POL];
                    st_d.fld_pol = wr_data[CTRL_FLD_POL];
                end
                default: ;
            endcase
        end
        st_d.hs_prev = hsync_in;
        if (restart) begin
            if (st_q.ref_emb) begin
                st_d.line_valid = ~code_v;
                st_d.field_odd  = ~code_f;
            end else begin
                st_d.line_valid = ~vblank_in;
                st_d.field_odd  = field_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.win_start  <= CNT_W'(RST_WIN_START);
            st_q.win_end    <= CNT_W'(RST_WIN_END);
            st_q.line_total <= CNT_W'(RST_LINE_TOTAL);
            st_q.sync_start <= CNT_W'(RST_SYNC_START);
            st_q.sync_end   <= CNT_W'(RST_SYNC_END);
        end else begin
            st_q <= st_d;
        end
    end

    assign comp_o       = pipe_comp;
    assign valid_line_o = st_q.line_valid ^ st_q.vld_pol;
    assign field_o      = st_q.field_odd ^ st_q.fld_pol;

endmodule

// File: rtl/vlt_checker.sv
module vlt_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic [CNT_W-1:0] cnt,
    input logic             win,
    input logic [1:0]       comp,
    input logic             half
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    assert_lead_cb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win) |-> (comp == 2'd0));

    assert_tag_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !win |-> (comp == 2'd0));

    assert_lead_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win) |-> half);

    assert_half_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$rose(win)) |-> (half != $past(half)));

endmodule

bind vid_line_timer vlt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cnt     (cnt),
    .win     (window_o),
    .comp    (comp_o),
    .half    (half_clk_o)
);

// File: tb/vid_line_timer_tb.sv
module vid_line_timer_tb;

    localparam int CLK_P = 10;
    localparam int PIPE  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = '0;
    logic        hsync_in = 1'b0, vblank_in = 1'b0, field_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [7:0]  dout;
    logic        window_o, sync_o, half_clk_o, valid_line_o, field_o;
    logic [1:0]  comp_o;

    vid_line_timer u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .hsync_in(hsync_in),
        .vblank_in(vblank_in), .field_in(field_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout), .window_o(window_o),
        .comp_o(comp_o), .sync_o(sync_o), .half_clk_o(half_clk_o),
        .valid_line_o(valid_line_o), .field_o(field_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    string phase = "init";

    // model state
    int k = 0;
    int m_cnt = 0, m_start = 8, m_end = 39, m_total = 64, m_ss = 0, m_se = 4;
    bit m_emb = 0, m_vpol = 0, m_fpol = 0, m_valid = 0, m_odd = 0, m_hsp = 0;
    int h1 = 0, h2 = 0, h3 = 0;
    int e_din[16], e_comp[16];
    bit e_win[16], e_sync[16], e_empty[16];
    bit o_win_prev = 0, o_half_prev = 0;

    task automatic chk(bit ok, string rq, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", rq, phase, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] b, input logic hs, input logic we,
                        input logic [2:0] wa, input logic [11:0] wd);
        int od = 0, oc = 0;
        bit ow = 0, os = 0, oe = 0, eh;
        int c;
        bit ev;
        if (k >= PIPE) begin
            od = e_din[(k-PIPE)%16]; ow = e_win[(k-PIPE)%16];
            oc = e_comp[(k-PIPE)%16]; os = e_sync[(k-PIPE)%16];
            oe = e_empty[(k-PIPE)%16];
        end
        eh = (k == 0) ? 1'b0 : ((ow && !o_win_prev) ? 1'b1 : !o_half_prev);
        chk(dout == 8'(od), "R2 dout", int'(dout), od);
        chk(window_o == ow, oe ? "R6 empty window" : "R5 window", int'(window_o), int'(ow));
        chk(comp_o == 2'(oc), "R7 tag", int'(comp_o), oc);
        chk(sync_o == os, "R10 sync", int'(sync_o), int'(os));
        chk(half_clk_o == eh, "R8 half clock", int'(half_clk_o), int'(eh));
        chk(valid_line_o == (m_valid ^ m_vpol), "R9 valid", int'(valid_line_o), int'(m_valid ^ m_vpol));
        chk(field_o == (m_odd ^ m_fpol), "R9 field", int'(field_o), int'(m_odd ^ m_fpol));
        o_win_prev = ow; o_half_prev = eh;

        din = b; hsync_in = hs; wr_en = we; wr_addr = wa; wr_data = wd;

        c = m_cnt;
        e_din[k%16]   = b;
        e_empty[k%16] = (m_end <= m_start);
        e_win[k%16]   = (m_end > m_start) && (c >= m_start) && (c <= m_end);
        e_comp[k%16]  = e_win[k%16] ? ((c - m_start) & 3) : 0;
        e_sync[k%16]  = m_emb && (c >= m_ss) && (c < m_se);
        if (m_emb) ev = (h3 == 8'hFF) && (h2 == 0) && (h1 == 0) && !b[4];
        else       ev = hs && !m_hsp;
        m_cnt = ev ? 0 : ((c >= m_total - 1) ? 0 : c + 1);
        if (ev) begin
            if (m_emb) begin m_valid = !b[5]; m_odd = !b[6]; end
            else begin m_valid = !vblank_in; m_odd = field_in; end
        end
        h3 = h2; h2 = h1; h1 = b; m_hsp = hs;
        if (we) begin
            case (wa)
                3'd0: m_start = wd;
                3'd1: m_end = wd;
                3'd2: m_total = wd;
                3'd3: m_ss = wd;
                3'd4: m_se = wd;
                3'd5: begin m_emb = wd[0]; m_vpol = wd[1]; m_fpol = wd[2]; end
                default: ;
            endcase
        end
        k++;
        @(negedge clk);
    endtask

    function automatic logic [7:0] pat();
        return 8'((k * 29 + 7) & 255);
    endfunction

    task automatic put(input logic [7:0] b, input logic hs);
        step(b, hs, 1'b0, 3'd0, 12'd0);
    endtask

    task automatic wreg(input logic [2:0] a, input int d);
        step(8'h80, 1'b0, 1'b1, a, 12'(d));
    endtask

    task automatic ext_line(input int len);
        put(pat(), 1'b1);
        for (int i = 1; i < len; i++) put(pat(), 1'b0);
    endtask

    task automatic emb_line(input bit f, input bit v, input int nb, input int na, input int hs_at);
        logic [7:0] fv;
        fv = {1'b0, f, v, 5'b0};
        put(8'hFF, 0); put(8'h00, 0); put(8'h00, 0); put(8'h90 | fv, 0);
        for (int i = 0; i < nb; i++) put((i % 2) ? 8'h10 : 8'h80, i == hs_at);
        put(8'hFF, 0); put(8'h00, 0); put(8'h00, 0); put(8'h80 | fv, 0);
        for (int i = 0; i < na; i++) put(pat(), i == hs_at);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        phase = "R1 reset";
        chk(dout == 0, "R1 dout", int'(dout), 0);
        chk(window_o == 0, "R1 window", int'(window_o), 0);
        chk(comp_o == 0, "R1 tag", int'(comp_o), 0);
        chk(sync_o == 0, "R1 sync", int'(sync_o), 0);
        chk(half_clk_o == 0, "R1 half", int'(half_clk_o), 0);
        chk(valid_line_o == 0, "R1 valid", int'(valid_line_o), 0);
        chk(field_o == 0, "R1 field", int'(field_o), 0);
        rst_n = 1'b1;

        // default registers right after reset (count starts at 0)
        for (int i = 0; i < 70; i++) put(pat(), 1'b0);

        phase = "R3 wrap";
        wreg(3'd2, 24);
        put(pat(), 1'b1);
        for (int i = 0; i < 80; i++) put(pat(), 1'b0);

        phase = "R5/R6/R7 sweep";
        for (int s = 1; s <= 5; s++) begin
            for (int ei = 0; ei < 5; ei++) begin
                int e;
                case (ei)
                    0: e = s - 1;
                    1: e = s;
                    2: e = s + 1;
                    3: e = s + 7;
                    default: e = 23;
                endcase
                wreg(3'd0, s);
                wreg(3'd1, e);
                vblank_in = ei[0];
                field_in  = s[0];
                ext_line(24);
                ext_line((ei % 2) ? 30 : 17);
            end
        end

        phase = "R9 polarity";
        wreg(3'd5, 6);
        for (int i = 0; i < 4; i++) begin
            vblank_in = i[0]; field_in = i[1];
            ext_line(20 + i);
        end

        phase = "R10 external sync held";
        wreg(3'd3, 2);
        wreg(3'd4, 9);
        wreg(3'd0, 3);
        wreg(3'd1, 14);
        wreg(3'd5, 0);
        ext_line(24);
        ext_line(26);

        phase = "R4 embedded";
        wreg(3'd2, 40);
        wreg(3'd5, 1);
        for (int i = 0; i < 4; i++) emb_line(i[0], i[1], 8 + 2 * i, 20 + i, 3 + i);
        wreg(3'd5, 7);
        for (int i = 0; i < 4; i++) emb_line(i[1], i[0], 10, 24, 5);

        phase = "R11 unmapped writes";
        wreg(3'd6, 0);
        wreg(3'd7, 1);
        emb_line(1'b0, 1'b0, 10, 22, 2);
        emb_line(1'b1, 1'b1, 10, 22, 2);

        for (int i = 0; i < 6; i++) put(8'h00, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule